// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address presented to a synchronous pipelined SRAM during a four-beat burst. A burst opens when one of two active-low start strobes is sampled low. One strobe is meant for a processor and is gated by the primary chip enable. The other is meant for a cache controller and is never gated. On that edge the external address is captured. Each later clock edge with the advance strobe low moves the burst to the next beat. Only the two low address bits change during a burst. The upper bits stay fixed for the whole burst.

A mode pin chooses the order of the beats. When it is low, the low bits count upward from the captured value and wrap modulo four. When it is high, the low bits are the captured low bits XORed with the beat number. Boards normally tie the pin high or low. The output address is a register, so each decision appears on `addr_o` one clock after the inputs are sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is all zeros and the beat count is zero.
- R2: If `start_cache_ni` is sampled low on a rising edge, `addr_o` takes the value of `addr_i` after that edge and the beat count returns to zero. This does not depend on `ce_ni`.
- R3: A low `start_proc_ni` loads `addr_i` in the same way only when `ce_ni` is low. When `ce_ni` is high, the processor strobe has no effect.
- R4: An edge with `adv_ni` low and no effective start adds one to the beat count, modulo 4. Bits `addr_o[ADDR_W-1:2]` are left unchanged.
- R5: With `mode_i` = 0 on an advancing edge, `addr_o[1:0]` becomes (loaded low bits + beat count) mod 4. For example, a start of 2 gives 2,3,0,1.
- R6: With `mode_i` = 1 on an advancing edge, `addr_o[1:0]` becomes the loaded low bits XOR the beat count. For example, a start of 1 gives 1,0,3,2.
- R7: If an effective start and `adv_ni` low occur on the same edge, the start wins: `addr_i` is loaded and the beat count is cleared.
- R8: An edge with no effective start and `adv_ni` high leaves `addr_o` unchanged.
- R9: After four advances in one burst, `addr_o` again equals the address that was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| start_proc_ni | input | 1 | Processor burst-start strobe, active low, gated by `ce_ni` |
| start_cache_ni | input | 1 | Cache-controller burst-start strobe, active low |
| ce_ni | input | 1 | Primary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| addr_o | output | ADDR_W | Registered internal address |

## Verification
Two situations are hard to reach at random. The first is a processor strobe that must be ignored: it only arises when the chip enable is high, the cache strobe is idle and the advance strobe is also idle at the same moment. The second is the collision where a start and an advance land on the same edge. Directed phases create both conditions on purpose. They also run full linear and interleaved bursts that wrap past beat three. Constrained random traffic then changes `mode_i` in the middle of bursts. It checks each edge against a behavioural model of the base address and beat count.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORDER_LINEAR = 1'b0, ORDER_INTERLEAVE = 1'b1} burst_order_e;
endpackage

// File: rtl/bseq_start_ctl.sv
module bseq_start_ctl (
  input  logic start_proc_ni,
  input  logic start_cache_ni,
  input  logic ce_ni,
  input  logic adv_ni,
  output logic load_o,
  output logic step_o
);
  logic proc_ok;
  assign proc_ok = ~start_proc_ni & ~ce_ni;
  assign load_o  = ~start_cache_ni | proc_ok;
  // start has priority over advance
  assign step_o  = ~adv_ni & ~load_o;
endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt
  import bseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output beat_t cnt_o,
  output beat_t cnt_d_o
);
  beat_t cnt_q;

  always_comb begin
    cnt_d_o = cnt_q;
    if (load_i)      cnt_d_o = '0;
    else if (step_i) cnt_d_o = cnt_q + beat_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  assign cnt_o = cnt_q;

  assert_cnt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == '0);
  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_o == beat_t'($past(cnt_o) + 1));
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
(
  input  beat_t        base_i,
  input  beat_t        cnt_i,
  input  burst_order_e order_i,
  output beat_t        lane_o
);
  always_comb begin
    unique case (order_i)
      ORDER_INTERLEAVE: lane_o = base_i ^ cnt_i;
      default:          lane_o = base_i + cnt_i;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              start_proc_ni,
  input  logic              start_cache_ni,
  input  logic              ce_ni,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic load, step;
  beat_t cnt_q, cnt_d, base_q, base_d, lane_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  burst_order_e order;

  assign order = burst_order_e'(mode_i);

  bseq_start_ctl i_start (
    .start_proc_ni (start_proc_ni),
    .start_cache_ni(start_cache_ni),
    .ce_ni         (ce_ni),
    .adv_ni        (adv_ni),
    .load_o        (load),
    .step_o        (step)
  );

  bseq_beat_cnt i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .cnt_o  (cnt_q),
    .cnt_d_o(cnt_d)
  );

  assign base_d = load ? addr_i[BEAT_W-1:0] : base_q;

  bseq_order i_order (
    .base_i (base_d),
    .cnt_i  (cnt_d),
    .order_i(order),
    .lane_o (lane_d)
  );

  always_comb begin
    addr_d = addr_q;
    if (load)      addr_d = addr_i;
    else if (step) addr_d = {addr_q[ADDR_W-1:BEAT_W], lane_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      base_q <= '0;
    end else begin
      addr_q <= addr_d;
      base_q <= base_d;
    end
  end

  assign addr_o = addr_q;

  initial begin
    if (UP_W < 1) $error("ADDR_W must exceed the beat width");
  end

  assert_load_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_cache_ni |=> addr_o == $past(addr_i));
  assert_proc_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && start_cache_ni && adv_ni) |=> $stable(addr_o));
  assert_upper_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  assert_linear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !mode_i) |=> addr_o[BEAT_W-1:0] == beat_t'(base_q + cnt_q));
  assert_interleave_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && mode_i) |=> addr_o[BEAT_W-1:0] == (base_q ^ cnt_q));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && adv_ni) |=> $stable(addr_o));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int ADDR_W = 18;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic proc_n = 1'b1, cache_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, mode = 1'b0;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int exp_addr = 0;
  int base_lo = 0;
  int beat = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .addr_i        (addr),
    .start_proc_ni (proc_n),
    .start_cache_ni(cache_n),
    .ce_ni         (ce_n),
    .adv_ni        (adv_n),
    .mode_i        (mode),
    .addr_o        (addr_out)
  );

  task automatic check(input string req, input int expv);
    checks++;
    if (int'(addr_out) != expv) begin
      errors++;
      $display("FAIL %s addr_o=%0h expected=%0h", req, addr_out, expv);
    end
  endtask

  // drive inputs at negedge, advance model, clock, compare at next negedge
  task automatic cyc(input string req, input int a, input bit pn, input bit cn,
                     input bit en, input bit vn, input bit m);
    bit ld;
    int lo;
    addr = ADDR_W'(a); proc_n = pn; cache_n = cn; ce_n = en; adv_n = vn; mode = m;
    ld = !cn || (!pn && !en);
    if (ld) begin
      exp_addr = a & ((1 << ADDR_W) - 1);
      base_lo = a & 3;
      beat = 0;
    end else if (!vn) begin
      beat = (beat + 1) % 4;
      lo = m ? (base_lo ^ beat) : ((base_lo + beat) % 4);
      exp_addr = (exp_addr & ~3) | lo;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, exp_addr);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    addr = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0);

    // R2 + R5 + R9: linear burst from low bits 2
    cyc("R2", 'h2A56, 1, 0, 1, 1, 0);
    cyc("R5", 0, 1, 1, 1, 0, 0);
    cyc("R5", 0, 1, 1, 1, 0, 0);
    cyc("R5", 0, 1, 1, 1, 0, 0);
    cyc("R9", 0, 1, 1, 1, 0, 0);
    cyc("R8", 'h1111, 1, 1, 0, 1, 0);

    // R6 interleaved from low bits 1
    cyc("R2", 'h3FFF5, 1, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) cyc("R6", 0, 1, 1, 1, 0, 1);

    // R3 processor strobe gated by chip enable
    cyc("R3", 'h00ABC, 0, 1, 1, 1, 0);
    cyc("R3", 'h00ABC, 0, 1, 1, 0, 1);
    cyc("R3", 'h12347, 0, 1, 0, 1, 0);
    cyc("R4", 0, 1, 1, 1, 0, 0);

    // R7 start collides with advance
    cyc("R4", 0, 1, 1, 1, 0, 0);
    cyc("R7", 'h0BEE3, 1, 0, 1, 0, 1);
    cyc("R7", 'h05552, 0, 1, 0, 0, 0);
    cyc("R8", 0, 1, 1, 0, 1, 1);

    // random traffic, mode may change mid-burst
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      cyc("R4", int'($urandom) & ((1 << ADDR_W) - 1),
          (r % 5) != 0, (r % 7) != 0, r[4], r[5] & r[6], r[7]);
    end

    // reset mid-burst
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", 0);
    exp_addr = 0; base_lo = 0; beat = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1", 0, 1, 1, 1, 0, 0);

    finish_run();
  end
endmodule